// File: doc/BRIEF.md
# Extended Cartridge Bank Mapper

This block translates CPU addresses from a 20-bit bus into physical addresses for a cartridge's ROM and RAM chips. A 6-bit linear bank register picks a 1 MiB ROM bank for the upper part of the address space. Three 10-bit bank registers each pick a 64 KiB bank: one for the RAM window and two for fixed ROM windows. The block drives a chip select for ROM, a chip select for RAM, a 26-bit physical address, and a byte-mode strobe for the ROM chip.

Software reaches every bank register through two byte-wide I/O ports that share one storage. The older port covers only the low byte. The newer port is split into a low byte and a high byte and gives access to the full width. A one-bit control register can map the ROM chip into the RAM window in place of RAM. Accesses in that window are always byte-wide, so software can program a flash device in system.

The register file is written on a rising clock edge. Reads and the address translation are combinational.

Top module: `ext_bank_mapper`

## Requirements
- R1: After reset, every register port reads 0x00. The ports are legacy linear 0xC0, legacy RAM bank 0xC1, legacy ROM0 bank 0xC2, legacy ROM1 bank 0xC3, flash control 0xCE, extended linear 0xCF, extended RAM bank low/high 0xD0/0xD1, ROM0 low/high 0xD2/0xD3 and ROM1 low/high 0xD4/0xD5. Because the registers reset to zero, the RAM window maps RAM.
- R2: The linear bank register is 6 bits wide and is shared by ports 0xC0 and 0xCF. A write through either port stores data[5:0], both ports read back the stored value, and bits 7:6 read as zero.
- R3: A write to a legacy bank port (0xC1–0xC3) replaces bits 7:0 of the shared 10-bit register and leaves bits 9:8 unchanged.
- R4: A write to an extended low port (0xD0, 0xD2, 0xD4) stores bits 7:0, and the matching legacy port reads the same byte. A write to an extended high port (0xD1, 0xD3, 0xD5) stores data[1:0] into bits 9:8. The high port reads back bits 9:8 in positions 1:0, with bits 7:2 reading as zero.
- R5: A request with CPU address 0x40000–0xFFFFF asserts the ROM select only. The physical address is {linear_bank, cpu_addr[19:0]} and byte mode is low.
- R6: A request in 0x20000–0x2FFFF or 0x30000–0x3FFFF asserts the ROM select only. The physical address is {rom0_bank or rom1_bank, cpu_addr[15:0]} and byte mode is low.
- R7: With flash control bit 0 clear, a request in 0x10000–0x1FFFF asserts the RAM select only. The physical address is {ram_bank, cpu_addr[15:0]} and byte mode is high.
- R8: With flash control bit 0 set, a request in 0x10000–0x1FFFF asserts the ROM select only. The physical address is the same as in R7 and byte mode is high.
- R9: The flash control port stores only bit 0. Bits 7:1 read as zero.
- R10: Neither select is asserted for addresses 0x00000–0x0FFFF or when no request is present. In that case the physical address is zero and byte mode is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port number for register reads and writes |
| io_wr | input | 1 | Register write strobe |
| io_wdata | input | 8 | Register write data |
| io_rdata | output | 8 | Read data for the port on io_addr |
| mem_req | input | 1 | A CPU memory access is present |
| mem_addr | input | 20 | CPU memory address |
| rom_sel | output | 1 | ROM chip select |
| ram_sel | output | 1 | RAM chip select |
| phys_addr | output | 26 | Translated physical address |
| byte_mode | output | 1 | Byte-wide access to the ROM chip |

## Verification
The assertions check these properties on every cycle:
- The two chip selects are never asserted together.
- No select is asserted without a request.
- The RAM select appears only with byte mode and with the flash bit clear.
- A legacy write keeps bits 9:8 of its register.
- A high-byte write loads bits 9:8.
- The upper bits of the flash control port read as zero.

Only the bench scenarios can show the following:
- That two port aliases reach the same storage.
- That the composed physical addresses hold the exact bank values written earlier.
- That setting and then clearing the flash bit moves the RAM window from RAM to ROM and back again.

// File: rtl/mapper_pkg.sv
package mapper_pkg;

   // Software-visible port numbers. Software decodes these, so they are fixed.
   localparam logic [7:0] PORT_LIN_LEG  = 8'hC0;
   localparam logic [7:0] PORT_FLASH    = 8'hCE;
   localparam logic [7:0] PORT_LIN_EXT  = 8'hCF;
   localparam int         NUM_SEG       = 3;   // RAM window, ROM0, ROM1

   // Legacy single-byte port of 64 KiB window i (0 = RAM window).
   function automatic logic [7:0] seg_leg_port(input int i);
      return 8'(8'hC1 + i);
   endfunction

   // Low byte of the wide port of window i. The high byte follows at +1.
   function automatic logic [7:0] seg_lo_port(input int i);
      return 8'(8'hD0 + 2 * i);
   endfunction

   typedef enum logic [2:0] {
      WIN_NONE = 3'd0,
      WIN_RAM  = 3'd1,
      WIN_ROM0 = 3'd2,
      WIN_ROM1 = 3'd3,
      WIN_LIN  = 3'd4
   } win_e;

endpackage

// File: rtl/bank_reg.sv
module bank_reg #(
   parameter int         W       = 10,
   parameter logic [7:0] P_LEG   = 8'hC1,
   parameter logic [7:0] P_LO    = 8'hD0,
   parameter logic [7:0] P_HI    = 8'hD1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [7:0]   addr,
   input  logic [7:0]   wdata,
   output logic [W-1:0] q,
   output logic [7:0]   rdata
);

   localparam bit WIDE = (W > 8);

   if (W < 1 || W > 16) begin : g_bad_w
      $error("bank_reg: W must be 1..16");
   end

   logic hit_leg, hit_lo, hit_hi;
   assign hit_leg = (addr == P_LEG);
   assign hit_lo  = (addr == P_LO);
   assign hit_hi  = WIDE && (addr == P_HI);

   if (WIDE) begin : g_wide
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q <= '0;
         end else if (wr) begin
            if (hit_leg || hit_lo) q[7:0]   <= wdata;
            else if (hit_hi)       q[W-1:8] <= wdata[W-9:0];
         end
      end

      always_comb begin
         rdata = 8'h00;
         if (hit_leg || hit_lo) rdata = q[7:0];
         else if (hit_hi)       rdata = 8'(q[W-1:8]);
      end

      // R3
      legacy_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && hit_leg) |=> (q[W-1:8] == $past(q[W-1:8])));

      // R4
      hi_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (wr && hit_hi) |=> (q[W-1:8] == $past(wdata[W-9:0])));

      // R4
      hi_read_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
         hit_hi |-> ((rdata >> (W - 8)) == 8'h00));
   end else begin : g_narrow
      always_ff @(posedge clk) begin
         if (!rst_n)                        q <= '0;
         else if (wr && (hit_leg || hit_lo)) q <= wdata[W-1:0];
      end

      always_comb begin
         rdata = 8'h00;
         if (hit_leg || hit_lo) rdata = 8'(q);
      end

      // R2
      narrow_read_zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (hit_leg || hit_lo) |-> ((rdata >> W) == 8'h00));
   end

   logic unused_bits;
   assign unused_bits = ^wdata;

endmodule

// File: rtl/win_decode.sv
module win_decode
   import mapper_pkg::*;
#(
   parameter int CPU_AW = 20,
   parameter int WIN_AW = 16,
   parameter int LIN_W  = 6,
   parameter int BANK_W = 10,
   parameter int PA_W   = 26
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         mem_req,
   input  logic [CPU_AW-1:0]            mem_addr,
   input  logic [LIN_W-1:0]             lin_bank,
   input  logic [NUM_SEG-1:0][BANK_W-1:0] seg_bank,
   input  logic                         flash_en,
   output logic                         rom_sel,
   output logic                         ram_sel,
   output logic                         byte_mode,
   output logic [PA_W-1:0]              phys_addr
);

   localparam int SEL_W = CPU_AW - WIN_AW;

   if (SEL_W < 3) begin : g_bad_aw
      $error("win_decode: need at least 3 window select bits");
   end
   if (LIN_W + CPU_AW > PA_W || BANK_W + WIN_AW > PA_W) begin : g_bad_pa
      $error("win_decode: PA_W too narrow");
   end

   logic [SEL_W-1:0] sel;
   win_e             win;
   assign sel = mem_addr[CPU_AW-1:WIN_AW];

   always_comb begin
      if (!mem_req)                         win = WIN_NONE;
      else if (sel == SEL_W'(0))            win = WIN_NONE;
      else if (sel == SEL_W'(1))            win = WIN_RAM;
      else if (sel == SEL_W'(2))            win = WIN_ROM0;
      else if (sel == SEL_W'(3))            win = WIN_ROM1;
      else                                  win = WIN_LIN;
   end

   logic [PA_W-1:0] seg_pa [NUM_SEG];
   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg_pa
      assign seg_pa[i] = PA_W'({seg_bank[i], mem_addr[WIN_AW-1:0]});
   end

   always_comb begin
      rom_sel   = 1'b0;
      ram_sel   = 1'b0;
      byte_mode = 1'b0;
      phys_addr = '0;
      unique case (win)
         WIN_RAM: begin
            byte_mode = 1'b1;
            rom_sel   = flash_en;
            ram_sel   = !flash_en;
            phys_addr = seg_pa[0];
         end
         WIN_ROM0: begin
            rom_sel   = 1'b1;
            phys_addr = seg_pa[1];
         end
         WIN_ROM1: begin
            rom_sel   = 1'b1;
            phys_addr = seg_pa[2];
         end
         WIN_LIN: begin
            rom_sel   = 1'b1;
            phys_addr = PA_W'({lin_bank, mem_addr});
         end
         default: ;
      endcase
   end

   // R10
   no_req_no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_req |-> (!rom_sel && !ram_sel && !byte_mode));

   // R7
   ram_sel_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_sel |-> (byte_mode && !flash_en));

   // R8
   flash_window_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_mode && flash_en) |-> (rom_sel && !ram_sel));

   // R5
   wide_rom_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rom_sel && !byte_mode) |-> (phys_addr[WIN_AW-1:0] == mem_addr[WIN_AW-1:0]));

endmodule

// File: rtl/ext_bank_mapper.sv
module ext_bank_mapper
   import mapper_pkg::*;
#(
   parameter int CPU_AW = 20,
   parameter int WIN_AW = 16,
   parameter int LIN_W  = 6,
   parameter int BANK_W = 10,
   parameter int PA_W   = 26
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [7:0]      io_addr,
   input  logic            io_wr,
   input  logic [7:0]      io_wdata,
   output logic [7:0]      io_rdata,
   input  logic            mem_req,
   input  logic [19:0]     mem_addr,
   output logic            rom_sel,
   output logic            ram_sel,
   output logic [25:0]     phys_addr,
   output logic            byte_mode
);

   if (CPU_AW != 20 || PA_W != 26) begin : g_bad_top
      $error("ext_bank_mapper: port widths assume CPU_AW=20, PA_W=26");
   end
   if (BANK_W <= 8) begin : g_bad_bank
      $error("ext_bank_mapper: BANK_W must exceed the legacy byte");
   end

   logic [LIN_W-1:0]              lin_bank;
   logic [NUM_SEG-1:0][BANK_W-1:0] seg_bank;
   logic [7:0]                    lin_rd;
   logic [7:0]                    seg_rd [NUM_SEG];
   logic                          flash_en;

   bank_reg #(
      .W     (LIN_W),
      .P_LEG (PORT_LIN_LEG),
      .P_LO  (PORT_LIN_EXT),
      .P_HI  (8'h00)
   ) lin_reg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (io_wr),
      .addr  (io_addr),
      .wdata (io_wdata),
      .q     (lin_bank),
      .rdata (lin_rd)
   );

   for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
      bank_reg #(
         .W     (BANK_W),
         .P_LEG (seg_leg_port(i)),
         .P_LO  (seg_lo_port(i)),
         .P_HI  (8'(seg_lo_port(i) + 8'd1))
      ) seg_reg_i (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (io_wr),
         .addr  (io_addr),
         .wdata (io_wdata),
         .q     (seg_bank[i]),
         .rdata (seg_rd[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                              flash_en <= 1'b0;
      else if (io_wr && io_addr == PORT_FLASH) flash_en <= io_wdata[0];
   end

   always_comb begin
      io_rdata = lin_rd;
      for (int i = 0; i < NUM_SEG; i++) io_rdata = io_rdata | seg_rd[i];
      if (io_addr == PORT_FLASH) io_rdata = {7'b0, flash_en};
   end

   win_decode #(
      .CPU_AW (CPU_AW),
      .WIN_AW (WIN_AW),
      .LIN_W  (LIN_W),
      .BANK_W (BANK_W),
      .PA_W   (PA_W)
   ) dec_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .lin_bank  (lin_bank),
      .seg_bank  (seg_bank),
      .flash_en  (flash_en),
      .rom_sel   (rom_sel),
      .ram_sel   (ram_sel),
      .byte_mode (byte_mode),
      .phys_addr (phys_addr)
   );

   // R8
   sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rom_sel, ram_sel}));

   // R9
   flash_rd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == PORT_FLASH) |-> (io_rdata[7:1] == 7'b0));

   // R9
   flash_wr_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && io_addr == PORT_FLASH) |=> (io_addr != PORT_FLASH || io_rdata[0] == $past(io_wdata[0])));

endmodule

// File: tb/ext_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module ext_bank_mapper_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = 8'h00;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = 8'h00;
   logic [7:0]  io_rdata;
   logic        mem_req = 1'b0;
   logic [19:0] mem_addr = 20'h0;
   logic        rom_sel, ram_sel, byte_mode;
   logic [25:0] phys_addr;

   always #2 clk = !clk;

   ext_bank_mapper dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .io_addr   (io_addr),
      .io_wr     (io_wr),
      .io_wdata  (io_wdata),
      .io_rdata  (io_rdata),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .rom_sel   (rom_sel),
      .ram_sel   (ram_sel),
      .phys_addr (phys_addr),
      .byte_mode (byte_mode)
   );

   typedef struct {
      string       tag;
      bit          is_mem;
      logic [7:0]  rd;
      logic        rom, ram, bm;
      logic [25:0] pa;
   } item_t;

   item_t sbq[$];
   event  smp;
   int    errors = 0;
   int    checks = 0;
   bit    done = 1'b0;

   // Monitor: pops each expected item and compares it with the outputs.
   initial begin
      forever begin
         @(smp);
         #1;
         begin
            item_t it;
            it = sbq.pop_front();
            checks++;
            if (it.is_mem) begin
               if (rom_sel !== it.rom || ram_sel !== it.ram ||
                   byte_mode !== it.bm || phys_addr !== it.pa) begin
                  errors++;
                  $display("FAIL %s: rom=%b ram=%b byte=%b pa=%h expected rom=%b ram=%b byte=%b pa=%h",
                           it.tag, rom_sel, ram_sel, byte_mode, phys_addr,
                           it.rom, it.ram, it.bm, it.pa);
               end
            end else if (io_rdata !== it.rd) begin
               errors++;
               $display("FAIL %s: rdata=%h expected %h", it.tag, io_rdata, it.rd);
            end
         end
      end
   end

   task automatic io_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      item_t it;
      @(negedge clk);
      io_addr = a; io_wr = 1'b0;
      it.tag = tag; it.is_mem = 1'b0; it.rd = e;
      it.rom = 0; it.ram = 0; it.bm = 0; it.pa = '0;
      sbq.push_back(it);
      ->smp;
      #2;
   endtask

   task automatic chk_mem(input logic req, input logic [19:0] a, input logic r,
                          input logic m, input logic b, input logic [25:0] p,
                          input string tag);
      item_t it;
      @(negedge clk);
      mem_req = req; mem_addr = a;
      it.tag = tag; it.is_mem = 1'b1; it.rd = 8'h00;
      it.rom = r; it.ram = m; it.bm = b; it.pa = p;
      sbq.push_back(it);
      ->smp;
      #2;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] ports [12];
      ports = '{8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hCE, 8'hCF,
                8'hD0, 8'hD1, 8'hD2, 8'hD3, 8'hD4, 8'hD5};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state of every port and of the RAM window.
      foreach (ports[i]) chk_rd(ports[i], 8'h00, "R1 reset read");
      chk_mem(1, 20'h10000, 0, 1, 1, 26'h0, "R1 RAM mapped at reset");

      // R2: linear bank through both ports.
      io_write(8'hCF, 8'hFF);
      chk_rd(8'hC0, 8'h3F, "R2 legacy sees ext write");
      chk_rd(8'hCF, 8'h3F, "R2 ext readback");
      io_write(8'hC0, 8'h05);
      chk_rd(8'hCF, 8'h05, "R2 ext sees legacy write");

      // R4 then R3 on the RAM window bank.
      io_write(8'hD1, 8'hFF);
      chk_rd(8'hD1, 8'h03, "R4 high byte readback");
      io_write(8'hC1, 8'h5A);
      chk_rd(8'hD0, 8'h5A, "R4 low alias of legacy");
      chk_rd(8'hD1, 8'h03, "R3 legacy keeps high bits");
      chk_rd(8'hC1, 8'h5A, "R3 legacy readback");

      io_write(8'hD2, 8'h12);
      io_write(8'hD3, 8'h02);
      chk_rd(8'hC2, 8'h12, "R4 ROM0 legacy alias");
      chk_rd(8'hD3, 8'h02, "R4 ROM0 high");
      io_write(8'hD4, 8'h34);
      io_write(8'hD5, 8'h01);
      io_write(8'hC3, 8'h77);
      chk_rd(8'hD5, 8'h01, "R3 ROM1 high kept");
      chk_rd(8'hD4, 8'h77, "R3 ROM1 low replaced");

      // R5: linear window.
      chk_mem(1, 20'h45678, 1, 0, 0, 26'h0545678, "R5 linear low end");
      chk_mem(1, 20'hFFFFF, 1, 0, 0, 26'h05FFFFF, "R5 linear top");
      // R6: fixed ROM windows.
      chk_mem(1, 20'h2ABCD, 1, 0, 0, 26'h212ABCD, "R6 ROM0 window");
      chk_mem(1, 20'h30001, 1, 0, 0, 26'h1770001, "R6 ROM1 window");
      // R7: RAM window.
      chk_mem(1, 20'h1BEEF, 0, 1, 1, 26'h35ABEEF, "R7 RAM window");

      // R9 and R8: flash redirect.
      io_write(8'hCE, 8'hFF);
      chk_rd(8'hCE, 8'h01, "R9 flash control readback");
      chk_mem(1, 20'h1BEEF, 1, 0, 1, 26'h35ABEEF, "R8 ROM in RAM window");
      chk_mem(1, 20'h2ABCD, 1, 0, 0, 26'h212ABCD, "R8 ROM0 unaffected");
      io_write(8'hCE, 8'hFE);
      chk_rd(8'hCE, 8'h00, "R9 flash cleared");
      chk_mem(1, 20'h1BEEF, 0, 1, 1, 26'h35ABEEF, "R7 RAM restored");

      // R10: internal range and idle bus.
      chk_mem(1, 20'h0FFFF, 0, 0, 0, 26'h0, "R10 internal range");
      chk_mem(0, 20'h45678, 0, 0, 0, 26'h0, "R10 no request");
      chk_mem(0, 20'h1BEEF, 0, 0, 0, 26'h0, "R10 no request RAM window");

      @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule